// File: doc/BRIEF.md
# Quadrature Encoder Step Decoder

This block takes the two phase-shifted square waves of an incremental rotary or linear encoder and turns each qualified transition into a one-cycle count strobe and a direction bit. The outputs are meant to drive the enable and up/down inputs of a separate position counter. The direction comes from the phase relationship of the two waves. Software never steers the count direction, and the counter value follows the shaft angle by itself.

Both encoder lines are asynchronous to the block clock. Each goes through a two-stage synchronizer, and a transition is detected by comparing the synchronized level with its previous sample. A two-bit mode input sets the resolution. Mode 0 ignores all transitions. Modes 1 and 2 count only the transitions of one line, which gives twice the line rate. Mode 3 counts the transitions of both lines, which gives four times the line rate. If both lines change in the same sampled cycle, the step is illegal: the block flags it and does not count it.

Top module: `quad_step_decoder`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, cnt_en_o, cnt_up_o and bad_step_o are all 0.
- R2: With mode_i = 2'b00, a transition on either line never raises cnt_en_o.
- R3: With mode_i = 2'b01, each transition of chan_b_i alone gives one strobe, with cnt_up_o = 1 when the new B level equals the A level and 0 otherwise. Transitions of chan_a_i alone give no strobe.
- R4: With mode_i = 2'b10, each transition of chan_a_i alone gives one strobe, with cnt_up_o = 1 when the new A level differs from the B level and 0 otherwise. Transitions of chan_b_i alone give no strobe.
- R5: With mode_i = 2'b11, every single-line transition gives one strobe, with the direction rule of R3 for B transitions and of R4 for A transitions. One full forward cycle 00→10→11→01→00 (A,B) therefore gives four up strobes, and the reverse cycle gives four down strobes.
- R6: If both lines change in the same synchronized sample, bad_step_o pulses for one cycle and cnt_en_o stays 0. This holds in every mode.
- R7: An input change applied between rising edges shows up on the outputs after the third rising edge that follows it, for one cycle only. cnt_up_o is valid in that same cycle and is 0 whenever cnt_en_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Resolution select: 00 off, 01 B edges, 10 A edges, 11 both |
| chan_a_i | input | 1 | Encoder line A, asynchronous |
| chan_b_i | input | 1 | Encoder line B, asynchronous |
| cnt_en_o | output | 1 | One-cycle count strobe |
| cnt_up_o | output | 1 | Count direction, 1 = up, valid with cnt_en_o |
| bad_step_o | output | 1 | One-cycle flag for a simultaneous change on both lines |

## Verification
The hardest case to reach from the ports is the illegal step. Both lines have to flip inside the same synchronized sample, and a slow encoder model that moves one line at a time never does that. The bench writes both inputs on the same falling clock edge, so the two changes are guaranteed to land in the same synchronizer cycle. It then checks that the error flag rises with no strobe, and that a legal step taken afterwards still counts in the right direction. The exact three-edge latency is checked separately: the bench samples the outputs just before and just after the cycle in which the strobe should appear.

// File: rtl/quad_pkg.sv
package quad_pkg;

    typedef enum logic [1:0] {
        QM_OFF    = 2'b00,
        QM_B_EDGE = 2'b01,
        QM_A_EDGE = 2'b10,
        QM_BOTH   = 2'b11
    } qmode_e;

    typedef struct packed {
        logic en;
        logic up;
        logic err;
    } qstep_t;

    localparam qstep_t QSTEP_IDLE = '{en: 1'b0, up: 1'b0, err: 1'b0};

endpackage

// File: rtl/quad_sync.sv
module quad_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk_i) begin
            if (!rst_ni) pipe_q[g] <= '0;
            else         pipe_q[g] <= pipe_d[g];
        end
    end

    assign sync_o = pipe_q[LAST];

endmodule

// File: rtl/quad_edge_detect.sv
module quad_edge_detect #(
    parameter int WIDTH = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] edge_o
);
    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = level_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= prev_d;
    end

    for (genvar g = 0; g < WIDTH; g++) begin : g_edge
        assign edge_o[g] = level_i[g] ^ prev_q[g];
    end

endmodule

// File: rtl/quad_qualify.sv
module quad_qualify
    import quad_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  qmode_e mode_i,
    input  logic   lvl_a_i,
    input  logic   lvl_b_i,
    input  logic   edge_a_i,
    input  logic   edge_b_i,
    output qstep_t step_o
);
    qstep_t step_d, step_q;
    logic   use_a, use_b, both, dir_a, dir_b;

    always_comb begin
        use_a = 1'b0;
        use_b = 1'b0;
        unique case (mode_i)
            QM_B_EDGE: use_b = 1'b1;
            QM_A_EDGE: use_a = 1'b1;
            QM_BOTH: begin
                use_a = 1'b1;
                use_b = 1'b1;
            end
            default: ;
        endcase
        both   = edge_a_i & edge_b_i;
        dir_a  = lvl_a_i ^ lvl_b_i;
        dir_b  = ~(lvl_a_i ^ lvl_b_i);
        step_d = QSTEP_IDLE;
        step_d.err = both;
        step_d.en  = ~both & ((use_a & edge_a_i) | (use_b & edge_b_i));
        step_d.up  = step_d.en & (edge_a_i ? dir_a : dir_b);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) step_q <= QSTEP_IDLE;
        else         step_q <= step_d;
    end

    assign step_o = step_q;

    a_r6_no_count_on_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_q.err |-> !step_q.en);
    a_r6_error_needs_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_q.err |-> $past(edge_a_i && edge_b_i));
    a_r2_off_mode_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == QM_OFF) |=> !step_q.en);
    a_r3_b_mode_needs_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == QM_B_EDGE && !edge_b_i) |=> !step_q.en);
    a_r4_a_mode_needs_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == QM_A_EDGE && !edge_a_i) |=> !step_q.en);
    a_r7_dir_only_with_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_q.up |-> step_q.en);

endmodule

// File: rtl/quad_step_decoder.sv
module quad_step_decoder
    import quad_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] mode_i,
    input  logic       chan_a_i,
    input  logic       chan_b_i,
    output logic       cnt_en_o,
    output logic       cnt_up_o,
    output logic       bad_step_o
);
    localparam int NCH = 2;
    localparam int IA  = 0;
    localparam int IB  = 1;

    logic [NCH-1:0] lvl, edges;
    qstep_t         step;

    quad_sync #(.WIDTH(NCH), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({chan_b_i, chan_a_i}),
        .sync_o  (lvl)
    );

    quad_edge_detect #(.WIDTH(NCH)) u_edge (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .level_i (lvl),
        .edge_o  (edges)
    );

    quad_qualify u_qual (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .mode_i   (qmode_e'(mode_i)),
        .lvl_a_i  (lvl[IA]),
        .lvl_b_i  (lvl[IB]),
        .edge_a_i (edges[IA]),
        .edge_b_i (edges[IB]),
        .step_o   (step)
    );

    assign cnt_en_o   = step.en;
    assign cnt_up_o   = step.up;
    assign bad_step_o = step.err;

    a_r7_error_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bad_step_o && $past(rst_ni)) |=> !bad_step_o);
    a_r1_quiet_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(rst_ni) |-> !(cnt_en_o || bad_step_o));

endmodule

// File: tb/quad_step_decoder_tb.sv
module quad_step_decoder_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       a = 1'b0;
    logic       b = 1'b0;
    logic       en, up, err;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    quad_step_decoder u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .mode_i     (mode),
        .chan_a_i   (a),
        .chan_b_i   (b),
        .cnt_en_o   (en),
        .cnt_up_o   (up),
        .bad_step_o (err)
    );

    function automatic logic [2:0] expect_step(logic [1:0] m, logic oa, logic ob, logic na, logic nb);
        logic ea, eb, c, d;
        ea = oa ^ na;
        eb = ob ^ nb;
        if (ea && eb) return 3'b001;
        c = (m == 2'b01 && eb) || (m == 2'b10 && ea) || (m == 2'b11 && (ea || eb));
        d = c && (ea ? (na != nb) : (nb == na));
        return {c, d, 1'b0};
    endfunction

    task automatic chk(string tag, logic [2:0] act, logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s {en,up,err} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at a falling edge
    task automatic step_to(logic na, logic nb, string tag);
        logic [2:0] exp;
        exp = expect_step(mode, a, b, na, nb);
        a = na;
        b = nb;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(tag, {en, up, err}, exp);
        @(negedge clk);
        chk({tag, " single-cycle R7"}, {en, up, err}, 3'b000);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 in reset", {en, up, err}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {en, up, err}, 3'b000);
    endtask

    task automatic t_mode_off();
        mode = 2'b00;
        step_to(1'b1, 1'b0, "R2 off A edge");
        step_to(1'b1, 1'b1, "R2 off B edge");
        step_to(1'b0, 1'b1, "R2 off A edge");
        step_to(1'b0, 1'b0, "R2 off B edge");
    endtask

    task automatic t_mode_b();
        mode = 2'b01;
        step_to(1'b1, 1'b0, "R3 A ignored");
        step_to(1'b1, 1'b1, "R3 B up");
        step_to(1'b0, 1'b1, "R3 A ignored");
        step_to(1'b0, 1'b0, "R3 B up");
        step_to(1'b0, 1'b1, "R3 B down");
        step_to(1'b1, 1'b1, "R3 A ignored");
        step_to(1'b1, 1'b0, "R3 B down");
        step_to(1'b0, 1'b0, "R3 A ignored");
    endtask

    task automatic t_mode_a();
        mode = 2'b10;
        step_to(1'b1, 1'b0, "R4 A up");
        step_to(1'b1, 1'b1, "R4 B ignored");
        step_to(1'b0, 1'b1, "R4 A up");
        step_to(1'b0, 1'b0, "R4 B ignored");
        step_to(1'b0, 1'b1, "R4 B ignored");
        step_to(1'b1, 1'b1, "R4 A down");
        step_to(1'b1, 1'b0, "R4 B ignored");
        step_to(1'b0, 1'b0, "R4 A down");
    endtask

    task automatic t_mode_both();
        mode = 2'b11;
        step_to(1'b1, 1'b0, "R5 fwd 1");
        step_to(1'b1, 1'b1, "R5 fwd 2");
        step_to(1'b0, 1'b1, "R5 fwd 3");
        step_to(1'b0, 1'b0, "R5 fwd 4");
        step_to(1'b0, 1'b1, "R5 rev 1");
        step_to(1'b1, 1'b1, "R5 rev 2");
        step_to(1'b1, 1'b0, "R5 rev 3");
        step_to(1'b0, 1'b0, "R5 rev 4");
    endtask

    task automatic t_illegal();
        mode = 2'b11;
        step_to(1'b1, 1'b1, "R6 both change mode3");
        step_to(1'b0, 1'b1, "R6 legal after error");
        mode = 2'b01;
        step_to(1'b1, 1'b0, "R6 both change mode1");
        mode = 2'b00;
        step_to(1'b0, 1'b1, "R6 both change mode0");
        step_to(1'b0, 1'b0, "R6 return");
    endtask

    task automatic t_latency();
        mode = 2'b10;
        a = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R7 not before third edge", {en, up, err}, 3'b000);
        @(posedge clk);
        @(negedge clk);
        chk("R7 on third edge", {en, up, err}, 3'b110);
        @(negedge clk);
        chk("R7 pulse ends", {en, up, err}, 3'b000);
        step_to(1'b0, 1'b0, "R7 return");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_mode_off();
        t_mode_b();
        t_mode_a();
        t_mode_both();
        t_illegal();
        t_latency();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule